// File: doc/BRIEF.md
# CD Controller Interrupt Edge Generator

This block sits between a CD data controller and the sub-processor's interrupt input. The controller has two interrupt sources: end of a data transfer and completion of a decoder event. Each source has an enable bit and an active-low status bit. Together they drive an active-low combined interrupt line. The block raises the level-5 request only when that combined line becomes newly asserted, and only if the host-side mask allows level 5 at that moment. It does not raise the request again while a source is already holding the line.

The block also keeps the pending flags for all the other CPU interrupt levels. It applies the host interrupt mask, presents the highest pending and unmasked level, and clears pending flags when the CPU acknowledges. Register accesses and controller events reach the block as single-cycle strobes. All results are registered, so they are visible one cycle after the strobe.

Top module: `cdc_irq_gen`

## Requirements
- R1: After a synchronous reset, `cdc_int_n` is 1, every bit of `pending` is 0, `cpu_level` is 0 and `flag2` is 0.
- R2: `cdc_int_n` is 0 exactly when a source has both its status active and its bit set in the internal interrupt state. In `ctrl_data`, bit 0 enables transfer-end and bit 1 enables decoder.
- R3: A `xfer_done` with transfer-end enabled makes the transfer-end status active and sets its state bit. It requests level 5 only if the combined line was released just before.
- R4: A `dec_event` with the decoder enabled makes the decoder status active and sets its state bit. It requests level 5 whenever the transfer-end state bit is clear, even if the decoder bit is already set.
- R5: A `ctrl_wr` loads the enables and recomputes the state as (active status AND enable) for each source. It requests level 5 only if the state went from zero to nonzero.
- R6: A level-5 request sets `pending[5]` only if `mask[5]` was 1 before the strobe. A request lost this way is not recovered by setting the mask later.
- R7: `xfer_ack` deactivates the transfer-end status and state bit, and `stat_rd` does the same for the decoder. Neither strobe changes `pending`.
- R8: `cpu_level` is the highest N for which `pending[N]` and mask bit N are both 1, or 0 if there is none. `mask_wr` loads the mask, with bit N corresponding to level N.
- R9: `ack` with binary `ack_level` = N clears `pending[N]`. When N is 2, it also clears `flag2`.
- R10: When a set and an acknowledge of the same level fall in the same cycle, the flag ends up set.
- R11: `ext_req[N]` sets `pending[N]` for every level except 5, whose bit in `ext_req` is ignored. `ext_req[2]` also sets `flag2`.
- R12: An event whose source is disabled still makes its status active but raises nothing. A later `ctrl_wr` that enables that source asserts the line and requests level 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_wr | input | 1 | Load host interrupt mask |
| mask_data | input | 8 | New mask value, bit N for level N |
| ctrl_wr | input | 1 | Load controller interrupt enables |
| ctrl_data | input | 2 | Bit 0 transfer-end enable, bit 1 decoder enable |
| xfer_done | input | 1 | Transfer completion event |
| dec_event | input | 1 | Decoder completion event |
| xfer_ack | input | 1 | Transfer-end acknowledge write |
| stat_rd | input | 1 | Decoder status read |
| ext_req | input | 8 | Set pulses for other levels' pending flags |
| ack | input | 1 | CPU interrupt acknowledge |
| ack_level | input | 3 | Level being acknowledged |
| cdc_int_n | output | 1 | Combined controller interrupt line, active low |
| pending | output | 8 | Pending flags per level |
| cpu_level | output | 3 | Highest pending unmasked level |
| flag2 | output | 1 | Host-side level-2 flag |

## Verification
The bench builds the block with its default parameters: a 3-bit level (eight levels), the controller on level 5 and the host flag on level 2. With these values, the ignored `ext_req[5]` bit and the level-2 flag are both reachable. Masking level 5 alone leaves lower levels visible, and raising level 7 shows that priority runs above the controller level. The reference model steps the two sources through each edge case: a retrigger attempt while one source holds the line, a decoder event while another decoder event is still outstanding, and simultaneous set and acknowledge.

// File: rtl/cdc_irq_pkg.sv
// Shared types for the CD controller interrupt path.
// Assumes two controller sources; bit order matches the enable field.
package cdc_irq_pkg;
    typedef struct packed {
        logic dec;   // decoder source (ctrl_data bit 1)
        logic xfer;  // transfer-end source (ctrl_data bit 0)
    } src_bits_t;
endpackage

// File: rtl/cdc_src_ctrl.sv
// Controller side: enables, active-low status and the internal interrupt
// state of the two sources. Produces a one-cycle level-5 request strobe.
// Assumes strobes in one cycle are applied in the order: acknowledges,
// control write, transfer end, decoder event.
module cdc_src_ctrl
    import cdc_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      host_en,
    input  logic      ctrl_wr,
    input  src_bits_t ctrl_en,
    input  logic      xfer_done,
    input  logic      dec_event,
    input  logic      xfer_ack,
    input  logic      stat_rd,
    output src_bits_t irq_state,
    output logic      req
);
    src_bits_t state_q, stat_n_q, en_q;
    src_bits_t state_d, stat_n_d, en_d, prev;
    logic      raise;

    // Next-state of the source registers and edge decision for this cycle.
    always_comb begin
        state_d  = state_q;
        stat_n_d = stat_n_q;
        en_d     = en_q;
        prev     = '0;
        raise    = 1'b0;
        if (xfer_ack) begin
            stat_n_d.xfer = 1'b1;
            state_d.xfer  = 1'b0;
        end
        if (stat_rd) begin
            stat_n_d.dec = 1'b1;
            state_d.dec  = 1'b0;
        end
        if (ctrl_wr) begin
            prev    = state_d;
            en_d    = ctrl_en;
            state_d = src_bits_t'(~stat_n_d & en_d);
            if (prev == '0 && state_d != '0) raise = 1'b1;
        end
        if (xfer_done) begin
            stat_n_d.xfer = 1'b0;
            if (en_d.xfer) begin
                if (state_d == '0) raise = 1'b1;
                state_d.xfer = 1'b1;
            end
        end
        if (dec_event) begin
            stat_n_d.dec = 1'b0;
            if (en_d.dec) begin
                if (!state_d.xfer) raise = 1'b1;
                state_d.dec = 1'b1;
            end
        end
    end

    // Register the source state; status resets inactive (high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= '0;
            stat_n_q <= '1;
            en_q     <= '0;
        end else begin
            state_q  <= state_d;
            stat_n_q <= stat_n_d;
            en_q     <= en_d;
        end
    end

    assign irq_state = state_q;
    assign req       = raise & host_en;
endmodule

// File: rtl/irq_pending.sv
// Per-level pending flags plus the host level-2 flag.
// A set pulse wins over an acknowledge of the same level.
module irq_pending #(
    parameter int LVL_W      = 3,
    parameter int FLAG_LEVEL = 2,
    localparam int NLVL      = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLVL-1:0]  set_vec,
    input  logic             ack,
    input  logic [LVL_W-1:0] ack_level,
    output logic [NLVL-1:0]  pend,
    output logic             flag
);
    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        // One pending bit: set has priority over acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   pend[i] <= 1'b0;
            else if (set_vec[i])                          pend[i] <= 1'b1;
            else if (ack && ack_level == LVL_W'(i))       pend[i] <= 1'b0;
        end
    end

    // Host flag tied to the designated level.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        flag <= 1'b0;
        else if (set_vec[FLAG_LEVEL])                      flag <= 1'b1;
        else if (ack && ack_level == LVL_W'(FLAG_LEVEL))   flag <= 1'b0;
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Highest-set-bit encoder; bit 0 and no bits both give zero.
module irq_prio_enc #(
    parameter int LVL_W = 3,
    localparam int NLVL = 1 << LVL_W
) (
    input  logic [NLVL-1:0]  act,
    output logic [LVL_W-1:0] level
);
    // Scan upward so the highest active level is kept.
    always_comb begin
        level = '0;
        for (int i = 0; i < NLVL; i++)
            if (act[i]) level = LVL_W'(i);
    end
endmodule

// File: rtl/cdc_irq_gen.sv
// Top: CD controller interrupt edge generator with host pending/mask logic.
// Assumes all control inputs are single-cycle strobes synchronous to clk.
module cdc_irq_gen
    import cdc_irq_pkg::*;
#(
    parameter int LVL_W      = 3,
    parameter int CDC_LEVEL  = 5,
    parameter int FLAG_LEVEL = 2,
    localparam int NLVL      = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic [NLVL-1:0]  mask_data,
    input  logic             ctrl_wr,
    input  logic [1:0]       ctrl_data,
    input  logic             xfer_done,
    input  logic             dec_event,
    input  logic             xfer_ack,
    input  logic             stat_rd,
    input  logic [NLVL-1:0]  ext_req,
    input  logic             ack,
    input  logic [LVL_W-1:0] ack_level,
    output logic             cdc_int_n,
    output logic [NLVL-1:0]  pending,
    output logic [LVL_W-1:0] cpu_level,
    output logic             flag2
);
    logic [NLVL-1:0] mask_q;
    logic [NLVL-1:0] set_vec;
    src_bits_t       irq_state;
    logic            cdc_req;

    // Host interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_data;
    end

    cdc_src_ctrl u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_en   (mask_q[CDC_LEVEL]),
        .ctrl_wr   (ctrl_wr),
        .ctrl_en   (src_bits_t'(ctrl_data)),
        .xfer_done (xfer_done),
        .dec_event (dec_event),
        .xfer_ack  (xfer_ack),
        .stat_rd   (stat_rd),
        .irq_state (irq_state),
        .req       (cdc_req)
    );

    // Merge external set pulses with the controller request on its level.
    always_comb begin
        set_vec            = ext_req;
        set_vec[CDC_LEVEL] = cdc_req;
    end

    irq_pending #(.LVL_W(LVL_W), .FLAG_LEVEL(FLAG_LEVEL)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .ack       (ack),
        .ack_level (ack_level),
        .pend      (pending),
        .flag      (flag2)
    );

    irq_prio_enc #(.LVL_W(LVL_W)) u_enc (
        .act   (pending & mask_q),
        .level (cpu_level)
    );

    assign cdc_int_n = (irq_state == '0);
endmodule

// File: rtl/cdc_irq_gen_chk.sv
// Checker for cdc_irq_gen, attached by bind below.
module cdc_irq_gen_chk #(
    parameter int LVL_W     = 3,
    parameter int CDC_LEVEL = 5,
    localparam int NLVL     = 1 << LVL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NLVL-1:0]  mask_q,
    input logic             ctrl_wr,
    input logic             xfer_done,
    input logic             dec_event,
    input logic             xfer_ack,
    input logic             stat_rd,
    input logic [NLVL-1:0]  ext_req,
    input logic             ack,
    input logic [LVL_W-1:0] ack_level,
    input logic             cdc_int_n,
    input logic [NLVL-1:0]  pending,
    input logic [LVL_W-1:0] cpu_level
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (pending == '0 && cdc_int_n)); // R1

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!cdc_int_n && xfer_done && !ctrl_wr && !dec_event && !xfer_ack && !stat_rd
         && !pending[CDC_LEVEL]) |=> !pending[CDC_LEVEL]); // R3

    AST_MASKED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[CDC_LEVEL] && !pending[CDC_LEVEL]) |=> !pending[CDC_LEVEL]); // R6

    AST_SOURCES_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && stat_rd && !ctrl_wr && !xfer_done && !dec_event) |=> cdc_int_n); // R7

    AST_LEVEL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level != '0) |-> (pending[cpu_level] && mask_q[cpu_level])); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_level != LVL_W'(CDC_LEVEL) && !ext_req[ack_level])
        |=> !pending[$past(ack_level)]); // R9
endmodule

bind cdc_irq_gen cdc_irq_gen_chk #(.LVL_W(LVL_W), .CDC_LEVEL(CDC_LEVEL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_q    (mask_q),
    .ctrl_wr   (ctrl_wr),
    .xfer_done (xfer_done),
    .dec_event (dec_event),
    .xfer_ack  (xfer_ack),
    .stat_rd   (stat_rd),
    .ext_req   (ext_req),
    .ack       (ack),
    .ack_level (ack_level),
    .cdc_int_n (cdc_int_n),
    .pending   (pending),
    .cpu_level (cpu_level)
);

// File: tb/cdc_irq_gen_test.sv
// Bench: behavioural reference model stepped and compared every clock.
module cdc_irq_gen_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mask_wr, ctrl_wr, xfer_done, dec_event, xfer_ack, stat_rd, ack;
    logic [7:0] mask_data, ext_req;
    logic [1:0] ctrl_data;
    logic [2:0] ack_level;
    logic       cdc_int_n, flag2;
    logic [7:0] pending;
    logic [2:0] cpu_level;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    bit   xs_act, ds_act, en_x, en_d, ix, id, m_flag;
    bit [7:0] m_mask, m_pend;

    always #5 clk = ~clk;

    cdc_irq_gen uut (.*);

    task automatic clear_in();
        mask_wr = 0; ctrl_wr = 0; xfer_done = 0; dec_event = 0; xfer_ack = 0;
        stat_rd = 0; ack = 0; mask_data = 0; ext_req = 0; ctrl_data = 0; ack_level = 0;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        bit raise = 0;
        bit wasz;
        bit [7:0] setv;
        int lvl = 0;
        if (!rst_n) begin
            {xs_act, ds_act, en_x, en_d, ix, id, m_flag} = '0;
            m_mask = 0; m_pend = 0;
        end else begin
            if (xfer_ack) begin xs_act = 0; ix = 0; end
            if (stat_rd)  begin ds_act = 0; id = 0; end
            if (ctrl_wr) begin
                wasz = !(ix || id);
                en_x = ctrl_data[0]; en_d = ctrl_data[1];
                ix = en_x && xs_act; id = en_d && ds_act;
                if (wasz && (ix || id)) raise = 1;
            end
            if (xfer_done) begin
                xs_act = 1;
                if (en_x) begin if (!ix && !id) raise = 1; ix = 1; end
            end
            if (dec_event) begin
                ds_act = 1;
                if (en_d) begin if (!ix) raise = 1; id = 1; end
            end
            setv = ext_req;
            setv[5] = raise && m_mask[5];
            for (int i = 0; i < 8; i++)
                if (setv[i]) m_pend[i] = 1;
                else if (ack && ack_level == i) m_pend[i] = 0;
            if (setv[2]) m_flag = 1;
            else if (ack && ack_level == 2) m_flag = 0;
            if (mask_wr) m_mask = mask_data;
        end
        for (int i = 0; i < 8; i++) if (m_pend[i] && m_mask[i]) lvl = i;
        @(posedge clk);
        #1;
        chk(tag, "cdc_int_n", cdc_int_n, !(ix || id));
        chk(tag, "pending", pending, m_pend);
        chk(tag, "cpu_level", cpu_level, lvl);
        chk(tag, "flag2", flag2, m_flag);
        clear_in();
    endtask

    initial begin
        #100000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 0;
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");
        // enable all levels, then transfer-end only
        mask_wr = 1; mask_data = 8'hFF; step("R8");
        ctrl_wr = 1; ctrl_data = 2'b01; step("R5");
        xfer_done = 1; step("R3");               // edge: pending5, level 5
        ack = 1; ack_level = 5; step("R9");
        xfer_done = 1; step("R3");               // line already low: no request
        xfer_ack = 1; step("R7");                // line released, pending unchanged
        // both sources enabled
        ctrl_wr = 1; ctrl_data = 2'b11; step("R5");
        dec_event = 1; step("R4");
        ack = 1; ack_level = 5; step("R9");
        dec_event = 1; step("R4");               // decoder bit set, xfer clear: request again
        ack = 1; ack_level = 5; step("R9");
        stat_rd = 1; step("R7");
        xfer_done = 1; step("R3");
        ack = 1; ack_level = 5; step("R9");
        dec_event = 1; step("R4");               // transfer-end holds line: no request
        xfer_ack = 1; stat_rd = 1; step("R2");
        // level 5 masked at the edge
        mask_wr = 1; mask_data = 8'hDF; step("R6");
        xfer_done = 1; step("R6");
        mask_wr = 1; mask_data = 8'hFF; step("R6");
        step("R6");
        xfer_ack = 1; step("R7");
        // disabled source, later enabled
        ctrl_wr = 1; ctrl_data = 2'b00; step("R12");
        xfer_done = 1; step("R12");
        ctrl_wr = 1; ctrl_data = 2'b01; step("R12");
        ack = 1; ack_level = 5; step("R9");
        ctrl_wr = 1; ctrl_data = 2'b01; step("R5");   // state stays nonzero
        xfer_ack = 1; step("R2");
        // other levels
        ext_req = 8'h24; step("R11");
        ext_req = 8'h80; step("R8");
        mask_wr = 1; mask_data = 8'h7F; step("R8");
        ack = 1; ack_level = 2; step("R9");
        ext_req = 8'h08; ack = 1; ack_level = 3; step("R10");
        ack = 1; ack_level = 7; step("R9");
        mask_wr = 1; mask_data = 8'hFF; step("R8");
        xfer_done = 1; ack = 1; ack_level = 5; step("R10");
        ack = 1; ack_level = 3; step("R8");
        step("R8");
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule